// File: doc/BRIEF.md
# One-Time-Programmable Cell Write Sequencer

This block programs a single 64-bit one-time-programmable cell, presented as a low and a high 32-bit word, and handles failed writes on its own. A command carries the cell offset, both data words, a repair-enable bit and a bit saying that the target is already the spare-row area. The sequencer puts the cell array in program mode and fires a one-cycle start strobe carrying address and data. It then waits for the array's program-ready flag and inspects the two program-error flags, one for correctable and one for uncorrectable errors.

A failing attempt is reissued to the same address with a retry qualifier, up to a fixed bound. When the bound is used up, the sequencer checks the cell itself. It passes through standby, switches to manual read mode with error responses suppressed, reads the low word and then the high word, and compares both with the intended data. If that check fails, and repair is allowed and the target is the normal array, a request/acknowledge handshake hands the write to a repair-record writer. The result of that write decides the outcome. Every command ends in standby, with a single-cycle done pulse and a pass bit.

Top module: `otp_prog_seq`

## Requirements
- R1: A command (cmd_valid high) is taken only while busy is low. cmd_valid while busy has no effect on the address, the data or the number of attempts. An offset of 0x2000 or above completes with done and pass low, and produces no start strobe.
- R2: Each attempt is one arr_start cycle, with arr_mode = 2 (program), arr_addr equal to the offset and arr_wlo/arr_whi equal to the data. The first attempt of a command has arr_retry low.
- R3: When arr_prog_rdy is seen with arr_perr_cor or arr_perr_unc high, the same address and data are reissued with arr_retry high. Either flag alone triggers this.
- R4: At most 10 retries follow the first attempt, so there are at most 11 start strobes. The retries output holds the number of retries issued and stays at 10 after the bound is reached.
- R5: After the bound, the mode goes to standby (0), then to manual read (1) with arr_err_resp_dis high. One read with arr_rd_sel = 0 (low word) comes first, then one with arr_rd_sel = 1 (high word). The check passes only when both words equal the command data.
- R6: If arr_rerr is high at the end of the check, the block pulses arr_rerr_clr and the check fails, even when the data match. A read error already pending before the reads is cleared first and does not fail the check.
- R7: A failed check with repair enabled and cmd_spare low raises rep_req, held until rep_ack, and pass then equals rep_ok. With repair disabled or cmd_spare high, no request is made and the command fails.
- R8: arr_mode is 0 (standby) whenever busy is low and during the done cycle.
- R9: done is high for exactly one cycle, with pass valid in that cycle. A write that succeeds on the first attempt reports retries = 0.
- R10: A synchronous active-low reset returns the block to idle: busy and done low, mode standby, retries 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_offset | input | 16 | Cell offset |
| cmd_lo | input | 32 | Low data word |
| cmd_hi | input | 32 | High data word |
| cmd_repair_en | input | 1 | Allow a repair request |
| cmd_spare | input | 1 | Target is the spare-row area |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with done |
| retries | output | 4 | Retries issued for the current command |
| arr_mode | output | 2 | Array mode: 0 standby, 1 manual read, 2 program |
| arr_err_resp_dis | output | 1 | Suppress read error responses |
| arr_start | output | 1 | Program start strobe |
| arr_retry | output | 1 | Retry qualifier with the start strobe |
| arr_addr | output | 13 | Cell address |
| arr_wlo | output | 32 | Low word to program |
| arr_whi | output | 32 | High word to program |
| arr_prog_rdy | input | 1 | Program cycle finished |
| arr_perr_cor | input | 1 | Correctable program error |
| arr_perr_unc | input | 1 | Uncorrectable program error |
| arr_rd_req | output | 1 | Manual read request |
| arr_rd_sel | output | 1 | Read word select, 0 low, 1 high |
| arr_rd_data | input | 32 | Read data |
| arr_rd_valid | input | 1 | Read data valid |
| arr_rerr | input | 1 | Sticky read error flag |
| arr_rerr_clr | output | 1 | Clear pulse for the read error flag |
| rep_req | output | 1 | Repair-record write request |
| rep_addr | output | 13 | Cell address for the repair |
| rep_lo | output | 32 | Low word for the repair |
| rep_hi | output | 32 | High word for the repair |
| rep_ack | input | 1 | Repair write finished |
| rep_ok | input | 1 | Repair write succeeded, valid with rep_ack |

## Verification
Two events can meet in the final evaluation cycle: a read-back that matches the intended data, and a read-error flag raised during the same reads. The bench's cell model flags an error on a read whose data are correct. The command must then fail, or go to repair when repair is allowed, and the flag must be cleared. A pending flag left over from before the command must be cleared without failing the check. The retry bound is also probed from both sides: a write that succeeds on the eleventh attempt, and one that fails on all eleven.

// File: rtl/otp_seq_pkg.sv
`timescale 1ns/1ps
package otp_seq_pkg;
    typedef enum logic [1:0] {
        MODE_STBY  = 2'd0,
        MODE_MREAD = 2'd1,
        MODE_MPROG = 2'd2
    } otp_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PSTART, ST_PWAIT, ST_VSTBY, ST_VRD_LO, ST_VWT_LO,
        ST_VRD_HI, ST_VWT_HI, ST_VEVAL, ST_REPAIR, ST_FINISH
    } seq_state_e;
endpackage

// File: rtl/otp_retry_ctr.sv
`timescale 1ns/1ps
module otp_retry_ctr #(
    parameter int MAX_RETRY = 10,
    parameter int CNT_W     = $clog2(MAX_RETRY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             at_limit
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt      = cnt_q;
    assign at_limit = (cnt_q == CNT_W'(MAX_RETRY));

    a_r4_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_RETRY));
    a_r4_no_inc_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !at_limit);
endmodule

// File: rtl/otp_word_cmp.sv
`timescale 1ns/1ps
module otp_word_cmp #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap_en,
    input  logic              cap_sel,
    input  logic [WORD_W-1:0] data,
    input  logic [WORD_W-1:0] exp_lo,
    input  logic [WORD_W-1:0] exp_hi,
    output logic              match
);
    logic [1:0]             got;
    logic [1:0][WORD_W-1:0] word;

    for (genvar g = 0; g < 2; g++) begin : g_slot
        logic [WORD_W-1:0] word_d, word_q;
        logic              got_d, got_q;

        always_comb begin
            word_d = word_q;
            got_d  = got_q;
            if (clr) begin
                got_d = 1'b0;
            end else if (cap_en && (cap_sel == 1'(g))) begin
                word_d = data;
                got_d  = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
                got_q  <= 1'b0;
            end else begin
                word_q <= word_d;
                got_q  <= got_d;
            end
        end

        assign got[g]  = got_q;
        assign word[g] = word_q;
    end

    assign match = &got && (word[0] == exp_lo) && (word[1] == exp_hi);

    a_r5_capture_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> !clr);
    a_r5_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && cap_sel) |-> got[0]);
endmodule

// File: rtl/otp_prog_seq.sv
`timescale 1ns/1ps
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int OFFS_W     = 16,
    parameter int CELL_LIMIT = 8192,
    parameter int WORD_W     = 32,
    parameter int MAX_RETRY  = 10,
    localparam int ADDR_W    = $clog2(CELL_LIMIT),
    localparam int CNT_W     = $clog2(MAX_RETRY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [OFFS_W-1:0] cmd_offset,
    input  logic [WORD_W-1:0] cmd_lo,
    input  logic [WORD_W-1:0] cmd_hi,
    input  logic              cmd_repair_en,
    input  logic              cmd_spare,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [CNT_W-1:0]  retries,
    output logic [1:0]        arr_mode,
    output logic              arr_err_resp_dis,
    output logic              arr_start,
    output logic              arr_retry,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [WORD_W-1:0] arr_wlo,
    output logic [WORD_W-1:0] arr_whi,
    input  logic              arr_prog_rdy,
    input  logic              arr_perr_cor,
    input  logic              arr_perr_unc,
    output logic              arr_rd_req,
    output logic              arr_rd_sel,
    input  logic [WORD_W-1:0] arr_rd_data,
    input  logic              arr_rd_valid,
    input  logic              arr_rerr,
    output logic              arr_rerr_clr,
    output logic              rep_req,
    output logic [ADDR_W-1:0] rep_addr,
    output logic [WORD_W-1:0] rep_lo,
    output logic [WORD_W-1:0] rep_hi,
    input  logic              rep_ack,
    input  logic              rep_ok
);
    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
        logic              rep_en;
        logic              spare;
        logic              pass;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    otp_mode_e        mode;
    logic             cnt_clr, cnt_inc, at_limit;
    logic [CNT_W-1:0] cnt;
    logic             cmp_clr, cap_en, cap_sel, match;
    logic             prog_err;

    assign prog_err = arr_perr_cor | arr_perr_unc;

    otp_retry_ctr #(.MAX_RETRY(MAX_RETRY), .CNT_W(CNT_W)) u_retry (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .cnt(cnt), .at_limit(at_limit)
    );

    otp_word_cmp #(.WORD_W(WORD_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clr(cmp_clr), .cap_en(cap_en),
        .cap_sel(cap_sel), .data(arr_rd_data), .exp_lo(s_q.lo),
        .exp_hi(s_q.hi), .match(match)
    );

    always_comb begin
        s_d              = s_q;
        mode             = MODE_STBY;
        arr_err_resp_dis = 1'b0;
        arr_start        = 1'b0;
        arr_rd_req       = 1'b0;
        arr_rd_sel       = 1'b0;
        arr_rerr_clr     = 1'b0;
        rep_req          = 1'b0;
        cnt_clr          = 1'b0;
        cnt_inc          = 1'b0;
        cmp_clr          = 1'b0;
        cap_en           = 1'b0;
        cap_sel          = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    s_d.addr   = cmd_offset[ADDR_W-1:0];
                    s_d.lo     = cmd_lo;
                    s_d.hi     = cmd_hi;
                    s_d.rep_en = cmd_repair_en;
                    s_d.spare  = cmd_spare;
                    s_d.pass   = 1'b0;
                    cnt_clr    = 1'b1;
                    if (cmd_offset >= OFFS_W'(CELL_LIMIT))
                        s_d.state = ST_FINISH;
                    else
                        s_d.state = ST_PSTART;
                end
            end
            ST_PSTART: begin
                mode      = MODE_MPROG;
                arr_start = 1'b1;
                s_d.state = ST_PWAIT;
            end
            ST_PWAIT: begin
                mode = MODE_MPROG;
                if (arr_prog_rdy) begin
                    if (!prog_err) begin
                        s_d.pass  = 1'b1;
                        s_d.state = ST_FINISH;
                    end else if (at_limit) begin
                        s_d.state = ST_VSTBY;
                    end else begin
                        cnt_inc   = 1'b1;
                        s_d.state = ST_PSTART;
                    end
                end
            end
            ST_VSTBY: begin
                arr_err_resp_dis = 1'b1;
                cmp_clr          = 1'b1;
                arr_rerr_clr     = arr_rerr;
                s_d.state        = ST_VRD_LO;
            end
            ST_VRD_LO: begin
                mode             = MODE_MREAD;
                arr_err_resp_dis = 1'b1;
                arr_rd_req       = 1'b1;
                s_d.state        = ST_VWT_LO;
            end
            ST_VWT_LO: begin
                mode             = MODE_MREAD;
                arr_err_resp_dis = 1'b1;
                if (arr_rd_valid) begin
                    cap_en    = 1'b1;
                    s_d.state = ST_VRD_HI;
                end
            end
            ST_VRD_HI: begin
                mode             = MODE_MREAD;
                arr_err_resp_dis = 1'b1;
                arr_rd_req       = 1'b1;
                arr_rd_sel       = 1'b1;
                s_d.state        = ST_VWT_HI;
            end
            ST_VWT_HI: begin
                mode             = MODE_MREAD;
                arr_err_resp_dis = 1'b1;
                arr_rd_sel       = 1'b1;
                if (arr_rd_valid) begin
                    cap_en    = 1'b1;
                    cap_sel   = 1'b1;
                    s_d.state = ST_VEVAL;
                end
            end
            ST_VEVAL: begin
                arr_err_resp_dis = 1'b1;
                arr_rerr_clr     = arr_rerr;
                if (match && !arr_rerr) begin
                    s_d.pass  = 1'b1;
                    s_d.state = ST_FINISH;
                end else if (s_q.rep_en && !s_q.spare) begin
                    s_d.state = ST_REPAIR;
                end else begin
                    s_d.pass  = 1'b0;
                    s_d.state = ST_FINISH;
                end
            end
            ST_REPAIR: begin
                rep_req = 1'b1;
                if (rep_ack) begin
                    s_d.pass  = rep_ok;
                    s_d.state = ST_FINISH;
                end
            end
            ST_FINISH: begin
                s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, addr: '0, lo: '0, hi: '0,
                     rep_en: 1'b0, spare: 1'b0, pass: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.state != ST_IDLE);
    assign done      = (s_q.state == ST_FINISH);
    assign pass      = s_q.pass;
    assign retries   = cnt;
    assign arr_mode  = mode;
    assign arr_retry = (cnt != '0);
    assign arr_addr  = s_q.addr;
    assign arr_wlo   = s_q.lo;
    assign arr_whi   = s_q.hi;
    assign rep_addr  = s_q.addr;
    assign rep_lo    = s_q.lo;
    assign rep_hi    = s_q.hi;

    a_r1_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_addr));
    a_r2_start_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |-> (arr_mode == 2'd2));
    a_r5_read_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd_req |-> ((arr_mode == 2'd1) && arr_err_resp_dis));
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_req && !rep_ack) |=> rep_req);
    a_r8_stby_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done || !busy) |-> (arr_mode == 2'd0));
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sim_otp_prog_seq.sv
`timescale 1ns/1ps
module sim_otp_prog_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_offset = '0;
    logic [31:0] cmd_lo = '0, cmd_hi = '0;
    logic        cmd_repair_en = 1'b0, cmd_spare = 1'b0;
    logic        busy, done, pass;
    logic [3:0]  retries;
    logic [1:0]  arr_mode;
    logic        arr_err_resp_dis, arr_start, arr_retry;
    logic [12:0] arr_addr, rep_addr;
    logic [31:0] arr_wlo, arr_whi, rep_lo, rep_hi;
    logic        arr_prog_rdy, arr_perr_cor, arr_perr_unc;
    logic        arr_rd_req, arr_rd_sel, arr_rd_valid, arr_rerr, arr_rerr_clr;
    logic [31:0] arr_rd_data;
    logic        rep_req, rep_ack, rep_ok;

    always #4 clk = ~clk;

    otp_prog_seq u0 (.*);

    // model configuration (driven by the stimulus only)
    int          cfg_fails = 0;
    logic        cfg_corrupt = 0, cfg_rerr = 0, cfg_rok = 0;
    logic [12:0] exp_addr = '0;
    logic        mon_clr = 0, rerr_preset = 0;

    // model / monitor state
    int   start_cnt, rd_cnt, seq_err, rep_cnt, pcnt, rwait;
    logic rep_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            arr_prog_rdy <= 1; arr_perr_cor <= 0; arr_perr_unc <= 0; pcnt <= 0;
            arr_rd_valid <= 0; arr_rd_data <= '0; arr_rerr <= 0;
            rep_ack <= 0; rep_ok <= 0; rwait <= 0; rep_prev <= 0;
            start_cnt <= 0; rd_cnt <= 0; seq_err <= 0; rep_cnt <= 0;
        end else begin
            arr_rd_valid <= 0;
            rep_ack <= 0;
            rep_prev <= rep_req;
            if (arr_start) begin
                arr_prog_rdy <= 0; arr_perr_cor <= 0; arr_perr_unc <= 0; pcnt <= 2;
                if (arr_addr != exp_addr || arr_wlo != cmd_lo || arr_whi != cmd_hi) seq_err <= seq_err + 1;
                if (arr_retry != (start_cnt != 0)) seq_err <= seq_err + 1;
                start_cnt <= start_cnt + 1;
            end else if (pcnt != 0) begin
                pcnt <= pcnt - 1;
                if (pcnt == 1) begin
                    arr_prog_rdy <= 1;
                    if (start_cnt <= cfg_fails) begin
                        if (start_cnt[0]) arr_perr_unc <= 1; else arr_perr_cor <= 1;
                    end
                end
            end
            if (arr_rd_req) begin
                arr_rd_valid <= 1;
                arr_rd_data  <= (arr_rd_sel ? cmd_hi : cmd_lo) ^ (cfg_corrupt ? 32'h100 : 32'h0);
                if (arr_rd_sel != rd_cnt[0]) seq_err <= seq_err + 1;
                rd_cnt <= rd_cnt + 1;
                if (cfg_rerr) arr_rerr <= 1;
            end
            if (rerr_preset) arr_rerr <= 1;
            if (arr_rerr_clr) arr_rerr <= 0;
            if (rep_req && !rep_ack) begin
                if (rwait == 2) begin rep_ack <= 1; rep_ok <= cfg_rok; rwait <= 0; end
                else rwait <= rwait + 1;
            end
            if (rep_req && !rep_prev) rep_cnt <= rep_cnt + 1;
            if (mon_clr) begin start_cnt <= 0; rd_cnt <= 0; seq_err <= 0; rep_cnt <= 0; end
        end
    end

    int total = 0, fails = 0, cyc = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    logic       got_pass;
    logic [3:0] got_ret;
    logic [1:0] got_mode;
    logic       got_done_next;

    task automatic run_cmd(input logic [15:0] off, input logic [31:0] lo, input logic [31:0] hi,
                           input logic ren, input logic sp);
        bit seen = 0;
        @(negedge clk);
        mon_clr = 1; exp_addr = off[12:0];
        cmd_valid = 1; cmd_offset = off; cmd_lo = lo; cmd_hi = hi;
        cmd_repair_en = ren; cmd_spare = sp;
        @(negedge clk);
        mon_clr = 0; cmd_valid = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            if (done) begin
                seen = 1; got_pass = pass; got_ret = retries; got_mode = arr_mode;
            end else @(negedge clk);
        end
        if (!seen) chk("R9 done timeout", 0, 1);
        @(negedge clk);
        got_done_next = done;
    endtask

    typedef struct packed {
        logic [7:0] fails;
        logic       corrupt, inj_rerr, rep_en, spare, rep_ok, exp_pass, exp_rep;
        logic [3:0] exp_ret;
        logic [7:0] exp_starts;
        logic [3:0] exp_reads;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'd0,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 4'd0,  8'd1,  4'd0},
        '{8'd3,  1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 4'd3,  8'd4,  4'd0},
        '{8'd10, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 4'd10, 8'd11, 4'd0},
        '{8'd11, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 4'd10, 8'd11, 4'd2},
        '{8'd11, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1, 4'd10, 8'd11, 4'd2},
        '{8'd11, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 4'd10, 8'd11, 4'd2},
        '{8'd11, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 4'd10, 8'd11, 4'd2},
        '{8'd11, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd10, 8'd11, 4'd2},
        '{8'd11, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd10, 8'd11, 4'd2},
        '{8'd11, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1, 4'd10, 8'd11, 4'd2}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 busy", busy, 0);
        chk("R10 done", done, 0);
        chk("R10 mode", arr_mode, 0);
        chk("R10 retries", retries, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R8 idle mode standby", arr_mode, 0);

        for (int v = 0; v < 10; v++) begin
            cfg_fails = VECS[v].fails; cfg_corrupt = VECS[v].corrupt;
            cfg_rerr = VECS[v].inj_rerr; cfg_rok = VECS[v].rep_ok;
            run_cmd(16'h0100 + 16'(v), 32'hA5A50000 + v, 32'h5A5A0000 ^ v,
                    VECS[v].rep_en, VECS[v].spare);
            chk($sformatf("R5 R6 R7 pass v%0d", v), got_pass, VECS[v].exp_pass);
            chk($sformatf("R4 R9 retries v%0d", v), got_ret, VECS[v].exp_ret);
            chk($sformatf("R4 starts v%0d", v), start_cnt, VECS[v].exp_starts);
            chk($sformatf("R5 reads v%0d", v), rd_cnt, VECS[v].exp_reads);
            chk($sformatf("R7 repair req v%0d", v), rep_cnt, VECS[v].exp_rep);
            chk($sformatf("R2 R3 R5 sequence v%0d", v), seq_err, 0);
            chk($sformatf("R8 mode at done v%0d", v), got_mode, 0);
            chk($sformatf("R9 done single v%0d", v), got_done_next, 0);
            chk($sformatf("R6 rerr cleared v%0d", v), arr_rerr, 0);
        end

        // R1: offset at the limit is refused
        cfg_fails = 0; cfg_corrupt = 0; cfg_rerr = 0;
        run_cmd(16'h2000, 32'h1, 32'h2, 1'b1, 1'b0);
        chk("R1 limit pass", got_pass, 0);
        chk("R1 limit starts", start_cnt, 0);
        run_cmd(16'h1FFF, 32'h11, 32'h22, 1'b0, 1'b0);
        chk("R1 last cell pass", got_pass, 1);
        chk("R2 last cell addr", seq_err, 0);

        // R6: stale read error cleared before reads, check passes
        cfg_fails = 11; cfg_corrupt = 0; cfg_rerr = 0;
        @(negedge clk); rerr_preset = 1;
        @(negedge clk); rerr_preset = 0;
        run_cmd(16'h0042, 32'hCAFE0001, 32'hBEEF0002, 1'b0, 1'b0);
        chk("R6 stale rerr pass", got_pass, 1);
        chk("R6 stale rerr cleared", arr_rerr, 0);

        // R1: command while busy is ignored
        cfg_fails = 2;
        @(negedge clk);
        mon_clr = 1; exp_addr = 13'h0077;
        cmd_valid = 1; cmd_offset = 16'h0077; cmd_lo = 32'h77; cmd_hi = 32'h88;
        cmd_repair_en = 0; cmd_spare = 0;
        @(negedge clk); mon_clr = 0; cmd_valid = 0;
        repeat (3) @(negedge clk);
        cmd_valid = 1; cmd_offset = 16'h0555;
        @(negedge clk); cmd_valid = 0; cmd_offset = 16'h0077;
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
        chk("R1 busy first pass", pass, 1);
        repeat (20) @(negedge clk);
        chk("R1 busy starts", start_cnt, 3);
        chk("R1 busy addr", seq_err, 0);
        chk("R1 busy idle after", busy, 0);

        // R10: reset in the middle of a command
        cfg_fails = 11;
        @(negedge clk);
        cmd_valid = 1; cmd_offset = 16'h0010;
        @(negedge clk); cmd_valid = 0;
        repeat (12) @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R10 midrun busy", busy, 0);
        chk("R10 midrun retries", retries, 0);
        chk("R10 midrun mode", arr_mode, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule